// File: doc/BRIEF.md
# Pipelined ADC Acquisition Sequencer

This block sits between an 8-bit host I/O bus and an eight-input, 12-bit serial analog-to-digital converter. The host writes a command byte that names an input and a mode. The block then drives one or two serial frames to the converter, captures the 12-bit sample and presents it in two byte-wide result registers. A ready flag in the command register shows when the sample can be read. A fixed identification byte sits at its own offset. Reads are combinational on the 3-bit offset. Writes take effect on a clock edge where the write strobe is high.

The converter has a one-frame pipeline. The sample returned during a frame comes from the input that was addressed in the frame before it. Fast mode runs a single frame, so it returns the input addressed last time. This suits streaming scans. Primed mode runs two frames that both address the requested input and keeps only the second result, so the sample always belongs to the input that was asked for.

Top module: `adcq_top`

## Requirements
- R1: After reset the ready flag (offset 0 bit 7) reads 1, both result bytes read 0, the chip select is high, the serial clock is low, and no frame starts until the command register is written.
- R2: Offset 1 always reads 0x97, and writes to it have no effect.
- R3: A write to offset 0 starts an acquisition. Bit 7 then reads 0 until the result is stored. Bits 6:0 read back the written byte, and the written bit 7 is ignored.
- R4: Offset 2 returns result bits 7:0. Offset 3 returns result bits 11:8 in bits 3:0, with bits 7:4 reading 0.
- R5: Each frame holds chip select low for exactly 16 serial clock pulses, and the serial clock idles low. Data is sent MSB first, with the input number (command bits 2:0) in word bits 13:11 and every other bit 0. The result is the last 12 of the 16 bits received, sampled on rising serial clock edges.
- R6: With command bit 4 = 1 (fast mode) one frame runs, and the result is the conversion of the input addressed in the preceding frame. Before the first frame after reset, that input is taken as 0.
- R7: With command bit 4 = 0 (primed mode) two frames run, both addressing the commanded input, and the result is the conversion of that input.
- R8: One frame lasts 1 + 32·DIV + QUIET system clocks. The ready flag returns to 1 exactly one frame after the command write in fast mode, and exactly two frames after it in primed mode.
- R9: A command write during an acquisition lets the current frame complete and discards its result. The block then restarts with the latest command, and the ready flag stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 3 | Register offset |
| hostWrData | input | 8 | Write data |
| hostWr | input | 1 | Write strobe, one cycle per write |
| hostRdData | output | 8 | Read data for hostAddr, combinational |
| sclk | output | 1 | Serial clock to the converter |
| csN | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial control word to the converter |
| miso | input | 1 | Serial sample from the converter |

## Verification
With the default divider of 12 and 65 quiet cycles, one frame is 450 clocks. The ready flag must therefore rise exactly 450 clocks after a fast-mode write edge and 900 clocks after a primed-mode one. The bench counts falling clock edges from the write edge until it reads the flag set, and compares that count with the exact value. Result bytes are read only after the flag is set. The command readback is taken on the first falling edge after the write, while the block is certain to be busy. A behavioural converter model follows the serial pins edge by edge, so the pipelined-input expectation is derived from the sequence of commands alone.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  typedef struct packed {
    logic loadTx;         // begin a frame: load control word, clear receiver
    logic sclkRise;       // sample miso
    logic sclkFall;       // advance control word
    logic captureResult;  // store received sample
  } adcqStrobe_t;

  localparam logic [7:0] ID_VALUE = 8'h97;
endpackage

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
  import adcq_pkg::*;
#(
  parameter int DIV        = 12,
  parameter int QUIET      = 65,
  parameter int FRAME_BITS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrCmd,
  input  logic        singleMode,
  output adcqStrobe_t strobe,
  output logic        busy,
  output logic        sclk,
  output logic        csN
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int Q_W   = (QUIET > 1) ? $clog2(QUIET) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_QUIET} state_t;

  state_t             state;
  logic [DIV_W-1:0]   divCnt;
  logic [Q_W-1:0]     qCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic               sclkR;
  logic               pending;
  logic               secondLeft;
  logic               fresh;

  logic tick, qEnd;
  assign tick = (divCnt == DIV_W'(DIV - 1));
  assign qEnd = (state == S_QUIET) && (qCnt == Q_W'(QUIET - 1));

  always_comb begin
    strobe.loadTx        = (state == S_LOAD);
    strobe.sclkRise      = (state == S_SHIFT) && tick && !sclkR;
    strobe.sclkFall      = (state == S_SHIFT) && tick && sclkR;
    strobe.captureResult = qEnd && !pending && !wrCmd && !secondLeft;
  end

  assign sclk = sclkR;
  assign csN  = (state != S_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      divCnt     <= '0;
      qCnt       <= '0;
      bitCnt     <= '0;
      sclkR      <= 1'b0;
      pending    <= 1'b0;
      secondLeft <= 1'b0;
      fresh      <= 1'b0;
      busy       <= 1'b0;
    end else begin
      if (wrCmd && state != S_IDLE && !qEnd) pending <= 1'b1;
      case (state)
        S_IDLE: begin
          if (wrCmd) begin
            state <= S_LOAD;
            busy  <= 1'b1;
            fresh <= 1'b1;
          end
        end
        S_LOAD: begin
          state  <= S_SHIFT;
          divCnt <= '0;
          bitCnt <= '0;
          sclkR  <= 1'b0;
          if (fresh) begin
            secondLeft <= !singleMode;
            fresh      <= 1'b0;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            sclkR  <= ~sclkR;
            if (sclkR) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == BIT_W'(FRAME_BITS - 1)) begin
                state <= S_QUIET;
                qCnt  <= '0;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        S_QUIET: begin
          if (qEnd) begin
            if (pending || wrCmd) begin
              state   <= S_LOAD;
              fresh   <= 1'b1;
              pending <= 1'b0;
            end else if (secondLeft) begin
              state      <= S_LOAD;
              secondLeft <= 1'b0;
            end else begin
              state <= S_IDLE;
              busy  <= 1'b0;
            end
          end else begin
            qCnt <= qCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Checker counter: serial clock pulses seen in the current frame.
  logic [BIT_W:0] fallCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                fallCnt <= '0;
    else if (strobe.loadTx)   fallCnt <= '0;
    else if (strobe.sclkFall) fallCnt <= fallCnt + 1'b1;
  end

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  p_frame_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (fallCnt == (BIT_W+1)'(FRAME_BITS)));
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd |=> busy);
  p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !wrCmd) |=> !busy);
  p_capture_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureResult |=> !busy);
endmodule

// File: rtl/adcq_datapath.sv
module adcq_datapath
  import adcq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int FRAME_BITS = 16,
  parameter int CHAN_W     = 3,
  parameter int CHAN_MSB   = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  adcqStrobe_t strobe,
  input  logic        wrCmd,
  input  logic        busy,
  input  logic [2:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  output logic        singleMode,
  output logic        mosi,
  input  logic        miso
);
  localparam int CHAN_LSB = CHAN_MSB - CHAN_W + 1;
  localparam int PAD_W    = 16;

  logic [7:0]            cmdReg;
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_W-1:0]     rxShift;
  logic [DATA_W-1:0]     result;
  logic [PAD_W-1:0]      resultPad;

  assign singleMode = cmdReg[4];
  assign mosi       = txShift[FRAME_BITS-1];
  assign resultPad  = PAD_W'(result);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      txShift <= '0;
      rxShift <= '0;
      result  <= '0;
    end else begin
      if (wrCmd) cmdReg <= hostWrData & 8'h7F;
      if (strobe.loadTx) begin
        txShift <= FRAME_BITS'(cmdReg[CHAN_W-1:0]) << CHAN_LSB;
        rxShift <= '0;
      end else begin
        if (strobe.sclkFall) txShift <= txShift << 1;
        if (strobe.sclkRise) rxShift <= {rxShift[DATA_W-2:0], miso};
      end
      if (strobe.captureResult) result <= rxShift;
    end
  end

  always_comb begin
    case (hostAddr)
      3'd0:    hostRdData = {~busy, 7'b0} | cmdReg;
      3'd1:    hostRdData = ID_VALUE;
      3'd2:    hostRdData = resultPad[7:0];
      3'd3:    hostRdData = {4'b0, resultPad[11:8]};
      default: hostRdData = '0;
    endcase
  end

  p_tx_msb_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTx |=> !mosi);
  p_result_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.captureResult) |=> $stable(result));
endmodule

// File: rtl/adcq_top.sv
module adcq_top
  import adcq_pkg::*;
#(
  parameter int DIV        = 12,
  parameter int QUIET      = 65,
  parameter int FRAME_BITS = 16,
  parameter int DATA_W     = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hostAddr,
  input  logic [7:0] hostWrData,
  input  logic       hostWr,
  output logic [7:0] hostRdData,
  output logic       sclk,
  output logic       csN,
  output logic       mosi,
  input  logic       miso
);
  adcqStrobe_t strobe;
  logic wrCmd, busy, singleMode;

  assign wrCmd = hostWr && (hostAddr == 3'd0);

  adcq_ctrl #(.DIV(DIV), .QUIET(QUIET), .FRAME_BITS(FRAME_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .wrCmd(wrCmd), .singleMode(singleMode),
    .strobe(strobe), .busy(busy), .sclk(sclk), .csN(csN)
  );

  adcq_datapath #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS), .CHAN_W(3), .CHAN_MSB(13)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrCmd(wrCmd), .busy(busy),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .singleMode(singleMode), .mosi(mosi), .miso(miso)
  );
endmodule

// File: tb/tb_adcq_top.sv
module tb_adcq_top;
  localparam int DIV   = 12;
  localparam int QUIET = 65;
  localparam int FRM   = 1 + 32*DIV + QUIET;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic hostWr = 1'b0;
  logic [7:0] hostRdData;
  logic sclk, csN, mosi;
  logic miso = 1'b0;

  always #10 clk = ~clk;

  adcq_top #(.DIV(DIV), .QUIET(QUIET)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWr(hostWr), .hostRdData(hostRdData), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  int vectors = 0;
  int errors  = 0;

  // Converter model: samples the input addressed in the previous frame.
  logic [11:0] convVal [8];
  logic [2:0]  convPrev = 3'd0;
  logic [15:0] misoSh = '0;
  logic [15:0] mosiCap = '0;
  int sclkCnt = 0;
  int frames = 0;
  bit armed = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge csN) if (armed) begin
    misoSh  = {4'b0, convVal[convPrev]};
    miso    = misoSh[15];
    mosiCap = '0;
    sclkCnt = 0;
  end
  always @(negedge sclk) if (armed && !csN) begin
    misoSh = misoSh << 1;
    miso   = misoSh[15];
  end
  always @(posedge sclk) if (armed) begin
    mosiCap = {mosiCap[14:0], mosi};
    sclkCnt++;
  end
  always @(posedge csN) if (armed) begin
    frames++;
    chk("R5 clocks per frame", 16'(sclkCnt), 16'd16);
    chk("R5 unused control bits", mosiCap & 16'hC7FF, 16'h0000);
    convPrev = mosiCap[13:11];
  end

  function automatic logic [2:0] expChan(input bit single, input logic [2:0] ch,
                                         input logic [2:0] prev);
    return single ? prev : ch;
  endfunction

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  logic [2:0] expPrev = 3'd0;

  task automatic waitReady(output int n, output bit stayedLow);
    logic [7:0] d;
    n = 0;
    stayedLow = 1;
    forever begin
      busRead(3'd0, d);
      if (d[7]) break;
      if (n > 3*FRM) begin
        errors++;
        $display("FAIL R8 ready timeout actual=%0d expected<=%0d", n, 2*FRM);
        break;
      end
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkResult(input string req, input logic [2:0] ch);
    logic [7:0] lo, hi;
    busRead(3'd2, lo);
    busRead(3'd3, hi);
    chk({req, " low byte R4"}, {8'h0, lo}, {8'h0, convVal[ch][7:0]});
    chk({req, " high byte R4"}, {8'h0, hi}, {12'h0, convVal[ch][11:8]});
  endtask

  task automatic runAcq(input logic [2:0] ch, input bit single, input logic [3:0] junk);
    logic [7:0] d, rb;
    int n;
    bit low;
    logic [2:0] want;
    d = {junk[3], junk[2:1], single, junk[0], ch};
    busWrite(3'd0, d);
    busRead(3'd0, rb);
    chk("R3 readback while busy", {8'h0, rb}, {8'h0, 1'b0, d[6:0]});
    waitReady(n, low);
    chk("R8 ready latency", 16'(n), 16'(single ? FRM : 2*FRM));
    want = expChan(single, ch, expPrev);
    expPrev = ch;
    checkResult(single ? "R6 fast" : "R7 primed", want);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    bit low;
    process::self().srandom(32'd1234);
    for (int i = 0; i < 8; i++) convVal[i] = 12'($urandom);
    convVal[7] = 12'hFFF;
    convVal[0] = 12'h000;
    convVal[3] = 12'hA5C;
    repeat (4) @(negedge clk);
    armed = 1;
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    busRead(3'd0, d); chk("R1 ready after reset", {15'h0, d[7]}, 16'h1);
    busRead(3'd2, d); chk("R1 result low zero", {8'h0, d}, 16'h0);
    busRead(3'd3, d); chk("R1 result high zero", {8'h0, d}, 16'h0);
    chk("R1 csN idle", {15'h0, csN}, 16'h1);
    chk("R1 sclk idle", {15'h0, sclk}, 16'h0);
    // R2 id register, write to it ignored
    busWrite(3'd1, 8'h00);
    busRead(3'd1, d); chk("R2 id value", {8'h0, d}, 16'h0097);
    repeat (1000) @(negedge clk);
    chk("R1 no frame before command", 16'(frames), 16'h0);

    // Directed: fast mode first after reset converts input 0
    runAcq(3'd3, 1'b1, 4'h0);
    runAcq(3'd7, 1'b1, 4'h0);  // converts 3
    runAcq(3'd7, 1'b1, 4'hF);  // converts 7, full scale, stray bits set
    runAcq(3'd3, 1'b0, 4'h0);  // primed
    busRead(3'd1, d); chk("R2 id while idle", {8'h0, d}, 16'h0097);

    // Random mix
    for (int k = 0; k < 24; k++) begin
      if (k % 6 == 0) for (int i = 0; i < 8; i++) convVal[i] = 12'($urandom);
      runAcq(3'($urandom), 1'($urandom), 4'($urandom));
    end

    // R9 restart: primed command on input 5, replaced by fast command on input 2
    busWrite(3'd0, 8'h05);
    repeat (200) @(negedge clk);
    busRead(3'd1, d); chk("R2 id while busy", {8'h0, d}, 16'h0097);
    busWrite(3'd0, 8'h12);
    busRead(3'd0, d); chk("R9 busy after second write", {15'h0, d[7]}, 16'h0);
    waitReady(n, low);
    chk("R9 restart completes in time", 16'(n <= 2*FRM), 16'h1);
    checkResult("R9 fast after abort", 3'd5);
    expPrev = 3'd2;

    // R9 restart: fast command replaced by primed command on input 6
    busWrite(3'd0, 8'h11);
    repeat (50) @(negedge clk);
    busWrite(3'd0, 8'h06);
    waitReady(n, low);
    chk("R9 primed restart latency bound", 16'(n <= 3*FRM), 16'h1);
    checkResult("R9 primed after abort", 3'd6);
    expPrev = 3'd6;
    runAcq(3'd0, 1'b1, 4'h0);  // converts 6

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule